// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits between an interrupt controller and a CPU's register file and data memory. When the controller raises a request and the sequencer is idle, it acknowledges the request and runs a short sequence. It pushes the interrupted program counter and then the status word onto a downward-growing word stack. It clears the live status register, which drops the global maskable enable and ends any low-power state. Finally, it reads the handler address from a vector table and loads it into the program counter.

A return command starts the reverse sequence. The status word is popped first and the program counter second, and the stack pointer moves back up. The sequencer restores whatever status word is in the stack slot at that moment. A handler that rewrites its stacked status word therefore decides the power and enable state the CPU returns to.

Every memory access takes exactly one state. The memory port is single-cycle, with read data returned combinationally in the cycle of the access. Register updates are offered as load strobes with the new value, and the surrounding register file takes them at the next clock edge.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `irq_ack`, `mem_we`, `mem_re`, `pc_load`, `sr_load` and `sp_load` are all low, and `mem_we` and `mem_re` are never high together.
- R2: In an idle cycle where `irq_req` is high and `reti_cmd` is low, `irq_ack` is high in that same cycle (cycle A). `busy` is high from cycle A through cycle A+3 and low in cycle A+4 when no new command arrives.
- R3: In cycle A+1 the block writes the program counter sampled in cycle A to address SP-2, where SP is the stack pointer sampled in cycle A. In the same cycle `sp_load` is high with `sp_out` = SP-2.
- R4: In cycle A+2 the block writes the status word sampled in cycle A to address SP-4. In the same cycle `sp_out` = SP-4 with `sp_load` high, and `sr_load` is high with `sr_out` = 0.
- R5: In cycle A+3 the block reads address VEC_BASE + 2*index, where the index is `irq_vec` sampled in cycle A. `pc_load` is high with `pc_out` equal to the read data.
- R6: While a sequence is running, no request is acknowledged. A request held high throughout an entry sequence is acknowledged again in cycle A+4.
- R7: In an idle cycle with `reti_cmd` high (cycle B), `busy` is high and there is no acknowledge. In cycle B+1 the block reads address SP and `sr_load` carries the read data, with `sp_out` = SP+2. In cycle B+2 it reads SP+2 and `pc_load` carries the read data, with `sp_out` = SP+4. In cycle B+3 `busy` is low.
- R8: The status word restored on return is the word in memory at that time. A handler's edit of the stacked status word therefore takes effect on return.
- R9: When `irq_req` and `reti_cmd` are both high in an idle cycle, the return runs and the request is not acknowledged. A request that is still held is acknowledged in cycle B+3.
- R10: `reti_cmd` asserted during an entry sequence has no effect. The entry completes unchanged and no return sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Pending interrupt request from the controller |
| irq_vec | input | VEC_W | Vector index of the pending request |
| irq_ack | output | 1 | Request accepted this cycle |
| reti_cmd | input | 1 | Return-from-interrupt command |
| busy | output | 1 | A sequence is running |
| mem_addr | output | AW | Byte address of the memory access |
| mem_we | output | 1 | Word write strobe |
| mem_re | output | 1 | Word read strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the same cycle as `mem_re` |
| pc_in | input | AW | Current program counter |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | AW | New program counter value |
| sr_in | input | DW | Current status register |
| sr_load | output | 1 | Load `sr_out` into the status register |
| sr_out | output | DW | New status register value |
| sp_in | input | AW | Current stack pointer |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | AW | New stack pointer value |

## Verification
A request for entry and a return command can arrive in the same idle cycle. The bench provokes this by raising both at the same falling edge after an entry sequence has filled the stack. It then expects no acknowledge, the two pops in the next two cycles, and the held request acknowledged in the cycle after the pops. The inverse overlap is also covered: a return command raised in the middle of an entry sequence. For that case the bench checks that the pushes and vector fetch proceed unchanged and that the stack pointer ends four bytes lower.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_PC = 3'd1,
    ST_PUSH_SR = 3'd2,
    ST_VEC     = 3'd3,
    ST_POP_SR  = 3'd4,
    ST_POP_PC  = 3'd5
  } seq_st_e;

endpackage

// File: rtl/trap_fsm.sv
module trap_fsm
  import trap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    irq_req,
  input  logic    reti_cmd,
  output seq_st_e state_o,
  output logic    accept_o,
  output logic    ret_start_o,
  output logic    busy_o
);

  seq_st_e state_q, state_d;
  logic    idle;

  assign idle        = (state_q == ST_IDLE);
  // return command wins over a request in the same idle cycle
  assign ret_start_o = idle && reti_cmd;
  assign accept_o    = idle && irq_req && !reti_cmd;
  assign busy_o      = !idle || accept_o || ret_start_o;
  assign state_o     = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ret_start_o)   state_d = ST_POP_SR;
        else if (accept_o) state_d = ST_PUSH_PC;
      end
      ST_PUSH_PC: state_d = ST_PUSH_SR;
      ST_PUSH_SR: state_d = ST_VEC;
      ST_VEC:     state_d = ST_IDLE;
      ST_POP_SR:  state_d = ST_POP_PC;
      ST_POP_PC:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen
  import trap_pkg::*;
#(
  parameter int             AW       = 16,
  parameter int             VEC_W    = 4,
  parameter logic [AW-1:0]  VEC_BASE = 'hFFE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           state_i,
  input  logic [AW-1:0]     sp_base_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     sp_next_o
);

  localparam int WORD_BYTES = 2;

  function automatic logic [AW-1:0] slot_below(input logic [AW-1:0] top, input int words);
    return top - AW'(WORD_BYTES * words);
  endfunction

  function automatic logic [AW-1:0] slot_above(input logic [AW-1:0] top, input int words);
    return top + AW'(WORD_BYTES * words);
  endfunction

  function automatic logic [AW-1:0] vec_slot(input logic [VEC_W-1:0] idx);
    return VEC_BASE + AW'({idx, 1'b0});
  endfunction

  always_comb begin
    addr_o    = '0;
    sp_next_o = sp_base_i;
    case (state_i)
      ST_PUSH_PC: begin addr_o = slot_below(sp_base_i, 1); sp_next_o = slot_below(sp_base_i, 1); end
      ST_PUSH_SR: begin addr_o = slot_below(sp_base_i, 2); sp_next_o = slot_below(sp_base_i, 2); end
      ST_VEC:     begin addr_o = vec_slot(vec_i); end
      ST_POP_SR:  begin addr_o = sp_base_i;                sp_next_o = slot_above(sp_base_i, 1); end
      ST_POP_PC:  begin addr_o = slot_above(sp_base_i, 1); sp_next_o = slot_above(sp_base_i, 2); end
      default: ;
    endcase
  end

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_PUSH_SR) |-> (addr_o == $past(addr_o) - AW'(WORD_BYTES)));

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int             AW       = 16,
  parameter int             DW       = 16,
  parameter int             VEC_W    = 4,
  parameter logic [AW-1:0]  VEC_BASE = 'hFFE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic              irq_ack,
  input  logic              reti_cmd,
  output logic              busy,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [AW-1:0]     pc_in,
  output logic              pc_load,
  output logic [AW-1:0]     pc_out,
  input  logic [DW-1:0]     sr_in,
  output logic              sr_load,
  output logic [DW-1:0]     sr_out,
  input  logic [AW-1:0]     sp_in,
  output logic              sp_load,
  output logic [AW-1:0]     sp_out
);

  seq_st_e            state;
  logic               accept, ret_start;
  logic [AW-1:0]      pc_q, sp_q, sp_next;
  logic [DW-1:0]      sr_q;
  logic [VEC_W-1:0]   vec_q;

  trap_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .reti_cmd   (reti_cmd),
    .state_o    (state),
    .accept_o   (accept),
    .ret_start_o(ret_start),
    .busy_o     (busy)
  );

  trap_addr_gen #(.AW(AW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .sp_base_i(sp_q),
    .vec_i    (vec_q),
    .addr_o   (mem_addr),
    .sp_next_o(sp_next)
  );

  // operands captured when a sequence starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sr_q  <= '0;
      sp_q  <= '0;
      vec_q <= '0;
    end else begin
      if (accept || ret_start) sp_q <= sp_in;
      if (accept) begin
        pc_q  <= pc_in;
        sr_q  <= sr_in;
        vec_q <= irq_vec;
      end
    end
  end

  logic in_push, in_pop;
  assign in_push = (state == ST_PUSH_PC) || (state == ST_PUSH_SR);
  assign in_pop  = (state == ST_POP_SR)  || (state == ST_POP_PC);

  assign irq_ack   = accept;
  assign mem_we    = in_push;
  assign mem_re    = in_pop || (state == ST_VEC);
  assign mem_wdata = (state == ST_PUSH_PC) ? DW'(pc_q) : sr_q;
  assign pc_load   = (state == ST_VEC) || (state == ST_POP_PC);
  assign pc_out    = AW'(mem_rdata);
  assign sr_load   = (state == ST_PUSH_SR) || (state == ST_POP_SR);
  assign sr_out    = (state == ST_POP_SR) ? mem_rdata : '0;
  assign sp_load   = in_push || in_pop;
  assign sp_out    = sp_next;

  // R1
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  // R2
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (busy && !irq_ack));

  // R4
  sr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_load && mem_we) |-> (sr_out == '0));

  // R5
  vec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !sp_load) |-> ($past(sr_load) && $past(mem_we)));

  // R7
  pop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_load && mem_re) |=> (pc_load && mem_re && sp_load));

endmodule

// File: tb/test_trap_sequencer.sv
module test_trap_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VBASE = 16'hFFE0;
  localparam int WATCHDOG = 20000;

  // {pc, sr, sp, vec, handler}
  localparam logic [67:0] VECS [4] = '{
    {16'h1234, 16'h00F8, 16'h0100, 4'd3,  16'hC000},
    {16'hABCE, 16'h0008, 16'h00F0, 4'd0,  16'hC100},
    {16'h0002, 16'hFFFF, 16'h0080, 4'd15, 16'hFFFE},
    {16'h7FFE, 16'h0010, 16'h00C0, 4'd9,  16'h8000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 1'b0;
  logic [3:0] irq_vec = '0;
  logic reti_cmd = 1'b0;
  logic irq_ack, busy, mem_we, mem_re, pc_load, sr_load, sp_load;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_out, sr_out, sp_out;
  logic [15:0] cur_pc = '0, cur_sr = '0, cur_sp = '0;
  logic [15:0] mem [256];
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer i_trap_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .reti_cmd(reti_cmd), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_in(cur_pc), .pc_load(pc_load),
    .pc_out(pc_out), .sr_in(cur_sr), .sr_load(sr_load), .sr_out(sr_out), .sp_in(cur_sp),
    .sp_load(sp_load), .sp_out(sp_out)
  );

  // memory and register file model
  assign mem_rdata = mem[mem_addr[8:1]];
  always @(posedge clk) begin
    if (mem_we)  mem[mem_addr[8:1]] <= mem_wdata;
    if (pc_load) cur_pc <= pc_out;
    if (sr_load) cur_sr <= sr_out;
    if (sp_load) cur_sp <= sp_out;
  end

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual cycles %0d expected below %0d", cyc, WATCHDOG);
      report();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic next_low;
    @(negedge clk); #1;
  endtask

  function automatic logic [15:0] vslot(input logic [3:0] v);
    return VBASE + 16'(v) * 16'd2;
  endfunction

  // called in a low phase; returns one low phase after busy falls
  task automatic run_entry(input logic [15:0] pc, sr, sp, input logic [3:0] v, input logic [15:0] hnd);
    logic [15:0] a;
    a = vslot(v);
    cur_pc = pc; cur_sr = sr; cur_sp = sp;
    mem[a[8:1]] = hnd;
    irq_vec = v; irq_req = 1'b1;
    #1;
    check("R2 ack in accept cycle", irq_ack, 1);
    check("R2 busy in accept cycle", busy, 1);
    @(negedge clk); irq_req = 1'b0; #1;
    check("R3 push pc strobe", {mem_we, mem_re, sp_load}, 3'b101);
    check("R3 push pc addr", mem_addr, sp - 16'd2);
    check("R3 push pc data", mem_wdata, pc);
    check("R3 sp after pc push", sp_out, sp - 16'd2);
    next_low();
    check("R4 push sr strobe", {mem_we, sr_load, sp_load}, 3'b111);
    check("R4 push sr addr", mem_addr, sp - 16'd4);
    check("R4 push sr data", mem_wdata, sr);
    check("R4 live sr cleared", sr_out, 16'h0000);
    check("R4 sp after sr push", sp_out, sp - 16'd4);
    next_low();
    check("R5 vector fetch strobe", {mem_re, pc_load, mem_we}, 3'b110);
    check("R5 vector addr", mem_addr, a);
    check("R5 handler to pc", pc_out, hnd);
    check("R2 busy through fetch", busy, 1);
    next_low();
    check("R2 busy low after entry", busy, 0);
    check("R5 model pc", cur_pc, hnd);
    check("R4 model sr", cur_sr, 16'h0000);
    check("R3 stacked pc", mem[(sp - 16'd2) >> 1 & 16'hFF], pc);
    check("R4 stacked sr", mem[(sp - 16'd4) >> 1 & 16'hFF], sr);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // reset
    #(CLK_PERIOD * 3);
    @(negedge clk); #1;
    check("R1 reset strobes", {busy, irq_ack, mem_we, mem_re, pc_load, sr_load, sp_load}, 7'b0);
    rst_n = 1'b1;
    next_low();
    check("R1 idle after reset", {busy, irq_ack, mem_we, mem_re, pc_load, sr_load, sp_load}, 7'b0);

    // table of entry vectors
    for (int k = 0; k < 4; k++)
      run_entry(VECS[k][67:52], VECS[k][51:36], VECS[k][35:20], VECS[k][19:16], VECS[k][15:0]);

    // R6: request held through a whole entry
    cur_pc = 16'h2000; cur_sr = 16'h0008; cur_sp = 16'h0100;
    mem[vslot(4'd2) >> 1 & 16'hFF] = 16'hD000;
    irq_vec = 4'd2; irq_req = 1'b1; #1;
    check("R6 first ack", irq_ack, 1);
    for (int c = 1; c <= 3; c++) begin
      next_low();
      check("R6 no ack while busy", irq_ack, 0);
    end
    next_low();
    check("R6 held request acked at A+4", irq_ack, 1);
    @(negedge clk); irq_req = 1'b0;
    next_low(); next_low(); next_low();
    check("R6 second entry done", busy, 0);

    // R7/R8: entry, handler edits stacked sr, return
    run_entry(16'h5550, 16'h00F0, 16'h0100, 4'd6, 16'hC600);
    mem[16'h00FC >> 1] = 16'h0008;
    reti_cmd = 1'b1; #1;
    check("R7 busy on return start", busy, 1);
    check("R7 no ack on return", irq_ack, 0);
    @(negedge clk); reti_cmd = 1'b0; #1;
    check("R7 pop sr strobe", {mem_re, sr_load, sp_load, pc_load}, 4'b1110);
    check("R7 pop sr addr", mem_addr, 16'h00FC);
    check("R8 edited sr restored", sr_out, 16'h0008);
    check("R7 sp after sr pop", sp_out, 16'h00FE);
    next_low();
    check("R7 pop pc strobe", {mem_re, pc_load, sp_load, sr_load}, 4'b1110);
    check("R7 pop pc addr", mem_addr, 16'h00FE);
    check("R7 pc restored", pc_out, 16'h5550);
    check("R7 sp after pc pop", sp_out, 16'h0100);
    next_low();
    check("R7 busy low after return", busy, 0);
    check("R8 model sr", cur_sr, 16'h0008);
    check("R7 model pc/sp", {cur_pc, cur_sp}, {16'h5550, 16'h0100});

    // R9: return and request in the same idle cycle
    run_entry(16'h3330, 16'h0018, 16'h0100, 4'd1, 16'hC110);
    mem[vslot(4'd7) >> 1 & 16'hFF] = 16'hC770;
    irq_vec = 4'd7; irq_req = 1'b1; reti_cmd = 1'b1; #1;
    check("R9 return wins, no ack", irq_ack, 0);
    @(negedge clk); reti_cmd = 1'b0; #1;
    check("R9 pop sr runs", {sr_load, mem_re, irq_ack}, 3'b110);
    check("R9 popped sr", sr_out, 16'h0018);
    next_low();
    check("R9 pop pc runs", {pc_load, irq_ack}, 2'b10);
    check("R9 popped pc", pc_out, 16'h3330);
    next_low();
    check("R9 held request acked at B+3", irq_ack, 1);
    @(negedge clk); irq_req = 1'b0;
    next_low(); next_low(); next_low();
    check("R9 entry after return", {busy, cur_pc}, {1'b0, 16'hC770});

    // R10: return command during an entry is ignored
    cur_pc = 16'h4440; cur_sr = 16'h0030; cur_sp = 16'h00E0;
    mem[vslot(4'd5) >> 1 & 16'hFF] = 16'hC550;
    irq_vec = 4'd5; irq_req = 1'b1; #1;
    check("R10 entry accepted", irq_ack, 1);
    @(negedge clk); irq_req = 1'b0; reti_cmd = 1'b1; #1;
    check("R10 pc push unchanged", {mem_we, mem_addr}, {1'b1, 16'h00DE});
    next_low();
    check("R10 sr push unchanged", {mem_we, mem_addr}, {1'b1, 16'h00DC});
    @(negedge clk); reti_cmd = 1'b0; #1;
    check("R10 vector fetch unchanged", {pc_load, pc_out}, {1'b1, 16'hC550});
    next_low();
    check("R10 no return follows", {busy, mem_re}, 2'b00);
    check("R10 sp after entry", cur_sp, 16'h00DC);
    next_low();
    check("R10 still idle", {busy, sp_load}, 2'b00);

    report();
  end

endmodule